// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This peripheral holds a set of independent down-counting timer channels behind a plain register bus made of an address, write data, a write strobe, a read strobe and registered read data. Each channel keeps a control word, a wide interval value and a wide running count. The count is split into a low and a high 32-bit half. A channel either runs periodically, reloading its interval every time it expires, or stops after a single expiry. A 3-bit prescaler setting in each control word slows that channel's tick rate by a power of two.

Every expiry sets the channel's pending bit in a shared status register. Software clears a pending bit by writing a one to it. A shared enable register masks the pending bits onto one interrupt line. A channel that is switched off keeps counting for a short drain window before it holds, so software must wait a few ticks before it programs that channel again. Reading the low count half captures the high half, so a high read that follows gives a coherent wide value.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads zero, no channel counts and `irq_o` is low.
- R2: Register map (byte addresses): interrupt enable at 0x00 and interrupt status at 0x04, with bit n for channel n. Channel n has control at 0x20*n+0x10, interval low at +0x14, interval high at +0x18, count low at +0x1C and count high at +0x20. Read data appears on `bus_rdata` on the cycle after the edge that samples `bus_re`. Enable and interval registers read back the value last written.
- R3: Control bits: 0 is run enable, 1 is reload, [6:4] is the prescaler select, 7 is one-shot, and bits 3:2 read as zero. A control write with bits 0 and 1 both set loads the interval into the count on the edge that samples the write, and the channel counts from the next edge onward.
- R4: With prescaler select p, the channel ticks once every 2^p clocks. Each tick lowers a nonzero count by one. A tick that finds the count at zero is an expiry, so a load with interval V expires (V+1)*2^p clocks after the loading edge.
- R5: In periodic mode (bit 7 clear), an expiry reloads the interval and the channel keeps running at the same period.
- R6: In one-shot mode (bit 7 set), an expiry stops the channel with its count held at zero, and control bit 0 then reads zero.
- R7: A control write that clears bit 0 on a running channel reads back at once, but the count still decrements on the sampling edge and on the 2 edges after it, then holds.
- R8: Each expiry sets the channel's status bit. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some channel has both its status bit and its enable bit set.
- R10: A read of count low captures the channel's high count half, and the next count-high read returns that captured half.
- R11: A control write with bit 0 set and bit 1 clear resumes counting from the held count, without a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt, the OR of the enabled pending bits |

## Verification
The bench builds the block with its defaults: two channels, a 64-bit count, a 32-bit bus and a drain window of 2. With two channels, the shared enable mask can be checked in both directions, because one channel can be pending while it is masked and the other is unmasked. The 64-bit count loaded with only the high half set carries across the halves on its first tick, which makes the captured high half observably different from the live one. Short intervals with prescaler settings 0 and 1 keep every expiry and every drain edge within a handful of cycles, so the bench checks each one on its exact clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PS_W        = 3;
  localparam int CTRL_W      = 8;
  localparam int OFF_IEN     = 'h00;
  localparam int OFF_IST     = 'h04;
  localparam int CH_BASE     = 'h10;
  localparam int CH_STRIDE   = 'h20;
  localparam int SUB_CTRL    = 'h00;
  localparam int SUB_IVL_LO  = 'h04;
  localparam int SUB_IVL_HI  = 'h08;
  localparam int SUB_CNT_LO  = 'h0C;
  localparam int SUB_CNT_HI  = 'h10;

  typedef struct packed {
    logic            oneshot;
    logic [PS_W-1:0] ps;
    logic [1:0]      spare;
    logic            reload;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_d;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = (DIV_W'(1) << sel_i) - DIV_W'(1);
    tick_o = run_i && ((pre_q & mask) == mask);
    pre_d = pre_q;
    if (restart_i)  pre_d = '0;
    else if (run_i) pre_d = pre_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int STOP_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_we_i,
  input  logic                    ivl_lo_we_i,
  input  logic                    ivl_hi_we_i,
  input  logic                    lo_rd_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output ctrl_t                   ctrl_o,
  output logic [CNT_W-1:0]        ivl_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-DATA_W-1:0] hi_shadow_o,
  output logic                    expire_o
);
  localparam int HI_W   = CNT_W - DATA_W;
  localparam int STOP_W = $clog2(STOP_LAT + 2);

  ctrl_t             ctrl_q, ctrl_d, wr_ctrl;
  logic [CNT_W-1:0]  ivl_q, ivl_d, cnt_q, cnt_d;
  logic [HI_W-1:0]   shadow_q, shadow_d;
  logic [STOP_W-1:0] stop_q, stop_d;
  logic              running_q, running_d;
  logic              load, resume, halt, tick, expire;

  always_comb begin
    wr_ctrl       = ctrl_t'(wdata_i[CTRL_W-1:0]);
    wr_ctrl.spare = '0;
    load   = ctrl_we_i && wr_ctrl.en && wr_ctrl.reload;
    resume = ctrl_we_i && wr_ctrl.en && !wr_ctrl.reload;
    halt   = ctrl_we_i && !wr_ctrl.en && running_q;
  end

  tmr_prescaler #(.PS_W(PS_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (running_q),
    .restart_i (load),
    .sel_i     (ctrl_q.ps),
    .tick_o    (tick)
  );

  assign expire = tick && (cnt_q == '0);

  always_comb begin
    ctrl_d    = ctrl_q;
    ivl_d     = ivl_q;
    cnt_d     = cnt_q;
    shadow_d  = shadow_q;
    stop_d    = stop_q;
    running_d = running_q;

    if (ivl_lo_we_i) ivl_d[DATA_W-1:0]     = wdata_i;
    if (ivl_hi_we_i) ivl_d[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
    if (lo_rd_i)     shadow_d              = cnt_q[CNT_W-1:DATA_W];

    if (tick) begin
      if (cnt_q != '0)         cnt_d = cnt_q - CNT_W'(1);
      else if (!ctrl_q.oneshot) cnt_d = ivl_q;
    end

    if (stop_q != '0) begin
      stop_d = stop_q - STOP_W'(1);
      if (stop_q == STOP_W'(1)) running_d = 1'b0;
    end

    if (expire && ctrl_q.oneshot) begin
      running_d = 1'b0;
      ctrl_d.en = 1'b0;
      stop_d    = '0;
    end

    if (ctrl_we_i) begin
      ctrl_d = wr_ctrl;
      if (halt) begin
        if (STOP_LAT == 0) running_d = 1'b0;
        else               stop_d    = STOP_W'(STOP_LAT);
      end
    end

    if (load) begin
      cnt_d     = ivl_q;
      running_d = 1'b1;
      stop_d    = '0;
    end else if (resume) begin
      running_d = 1'b1;
      stop_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ivl_q     <= '0;
      cnt_q     <= '0;
      shadow_q  <= '0;
      stop_q    <= '0;
      running_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      ivl_q     <= ivl_d;
      cnt_q     <= cnt_d;
      shadow_q  <= shadow_d;
      stop_q    <= stop_d;
      running_q <= running_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign ivl_o       = ivl_q;
  assign cnt_o       = cnt_q;
  assign hi_shadow_o = shadow_q;
  assign expire_o    = expire;

  // R3: a load puts the interval in the count and starts the channel
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(ivl_q)) && running_q);

  // R4: a tick lowers a nonzero count by exactly one
  p_decr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !load) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R5: a periodic expiry reloads the interval
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.oneshot && !load) |=> cnt_q == $past(ivl_q));

  // R6: a one-shot expiry stops the channel and drops its enable bit
  p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.oneshot && !ctrl_we_i) |=> !running_q && !ctrl_q.en);

  // R7: a stopped channel holds its count
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ien_we_i,
  input  logic              ist_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] ien_o,
  output logic [NUM_CH-1:0] ist_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ien_q, ien_d, ist_q, ist_d, clr;

  always_comb begin
    clr   = ist_we_i ? wdata_i : '0;
    ien_d = ien_we_i ? wdata_i : ien_q;
    ist_d = (ist_q & ~clr) | expire_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      ist_q <= '0;
    end else begin
      ien_q <= ien_d;
      ist_q <= ist_d;
    end
  end

  assign ien_o = ien_q;
  assign ist_o = ist_q;
  assign irq_o = |(ien_q & ist_q);

  // R8: an expiry always leaves its status bit set
  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i != '0) |=> (ist_q & $past(expire_i)) == $past(expire_i));

  // R8: a written one clears the bit unless an expiry arrives with it
  p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ist_we_i |=> (ist_q & $past(wdata_i & ~expire_i)) == '0);

  // R8: a status bit never sets without an expiry
  p_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i == '0) |=> (ist_q & ~$past(ist_q)) == '0);
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int STOP_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NUM_CH-1:0] expire, ien, ist;
  logic              hit_ien, hit_ist;
  logic [DATA_W-1:0] rd_ch [NUM_CH];
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign hit_ien = (bus_addr == ADDR_W'(OFF_IEN));
  assign hit_ist = (bus_addr == ADDR_W'(OFF_IST));

  tmr_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ien_we_i (bus_we && hit_ien),
    .ist_we_i (bus_we && hit_ist),
    .wdata_i  (bus_wdata[NUM_CH-1:0]),
    .expire_i (expire),
    .ien_o    (ien),
    .ist_o    (ist),
    .irq_o    (irq_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BASE = CH_BASE + CH_STRIDE * ch;
    logic             hit_ctrl, hit_ivl_lo, hit_ivl_hi, hit_cnt_lo, hit_cnt_hi;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] ivl, cnt;
    logic [HI_W-1:0]  shadow;

    assign hit_ctrl   = (bus_addr == ADDR_W'(BASE + SUB_CTRL));
    assign hit_ivl_lo = (bus_addr == ADDR_W'(BASE + SUB_IVL_LO));
    assign hit_ivl_hi = (bus_addr == ADDR_W'(BASE + SUB_IVL_HI));
    assign hit_cnt_lo = (bus_addr == ADDR_W'(BASE + SUB_CNT_LO));
    assign hit_cnt_hi = (bus_addr == ADDR_W'(BASE + SUB_CNT_HI));

    tmr_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W), .STOP_LAT(STOP_LAT)) u_chan (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .ctrl_we_i   (bus_we && hit_ctrl),
      .ivl_lo_we_i (bus_we && hit_ivl_lo),
      .ivl_hi_we_i (bus_we && hit_ivl_hi),
      .lo_rd_i     (bus_re && hit_cnt_lo),
      .wdata_i     (bus_wdata),
      .ctrl_o      (ctrl),
      .ivl_o       (ivl),
      .cnt_o       (cnt),
      .hi_shadow_o (shadow),
      .expire_o    (expire[ch])
    );

    always_comb begin
      rd_ch[ch] = '0;
      if (hit_ctrl)   rd_ch[ch] = DATA_W'(ctrl);
      if (hit_ivl_lo) rd_ch[ch] = ivl[DATA_W-1:0];
      if (hit_ivl_hi) rd_ch[ch] = DATA_W'(ivl[CNT_W-1:DATA_W]);
      if (hit_cnt_lo) rd_ch[ch] = cnt[DATA_W-1:0];
      if (hit_cnt_hi) rd_ch[ch] = DATA_W'(shadow);
    end

    // R10: the captured half matches the live high half sampled by the low read
    p_shadow_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
      (bus_re && hit_cnt_lo) |=> shadow == $past(cnt[CNT_W-1:DATA_W]));
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ien) rd_mux = DATA_W'(ien);
    if (hit_ist) rd_mux = DATA_W'(ist);
    for (int i = 0; i < NUM_CH; i++) rd_mux = rd_mux | rd_ch[i];
    rdata_d = bus_re ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R9: the line is high only when an enabled channel is pending
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (ien != '0) && (ist != '0));
endmodule

// File: tb/test_tmr_top.sv
module test_tmr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        chk_pend = 1'b0;

  always #2.5 clk = ~clk;

  tmr_top i_tmr_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // monitor: compare each read result against the scoreboard queue
  always @(posedge clk) chk_pend <= bus_re;
  always @(negedge clk) begin
    if (chk_pend) begin
      logic [31:0] e;
      string t;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_tests++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(8'h00, 32'h0, "R1 enable reg");
    rd(8'h04, 32'h0, "R1 status reg");
    rd(8'h10, 32'h0, "R1 ch0 control");
    rd(8'h1C, 32'h0, "R1 ch0 count low");

    // R2: readback
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h1, "R2 enable readback");
    wr(8'h14, 32'd5);
    wr(8'h18, 32'd0);
    rd(8'h14, 32'd5, "R2 interval low readback");

    // R3 R4 R6: one-shot, interval 5, prescaler 0 -> expiry 6 edges after load
    wr(8'h10, 32'h83);
    idle(5);
    chk_irq(1'b0, "R4 one-shot before expiry");
    idle(1);
    chk_irq(1'b1, "R4 one-shot expiry edge");
    rd(8'h1C, 32'h0, "R6 one-shot count held at zero");
    rd(8'h10, 32'h82, "R6 enable bit dropped");
    rd(8'h04, 32'h1, "R8 status set by expiry");

    // R8: write-one-to-clear
    wr(8'h04, 32'h0);
    rd(8'h04, 32'h1, "R8 zero write leaves status");
    chk_irq(1'b1, "R8 irq kept after zero write");
    wr(8'h04, 32'h1);
    chk_irq(1'b0, "R8 irq after clear");
    rd(8'h04, 32'h0, "R8 status after clear");

    // R4 R5: periodic, interval 2, prescaler 1 -> period 6
    wr(8'h14, 32'd2);
    wr(8'h10, 32'h13);
    idle(5);
    chk_irq(1'b0, "R4 prescaled before expiry");
    idle(1);
    chk_irq(1'b1, "R4 prescaled expiry edge");
    wr(8'h04, 32'h1);
    chk_irq(1'b0, "R8 cleared between periods");
    idle(4);
    chk_irq(1'b0, "R5 before second expiry");
    idle(1);
    chk_irq(1'b1, "R5 second expiry after reload");
    wr(8'h10, 32'h0);
    idle(20);
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R8 status clear after stop");

    // R7: drain window, interval 100, disable one edge after load
    wr(8'h14, 32'd100);
    wr(8'h10, 32'h03);
    wr(8'h10, 32'h00);
    rd(8'h10, 32'h0, "R7 disable reads back at once");
    idle(3);
    rd(8'h1C, 32'd97, "R7 count after drain");
    idle(10);
    rd(8'h1C, 32'd97, "R7 count held after drain");

    // R11: resume without reload
    wr(8'h10, 32'h01);
    idle(3);
    wr(8'h10, 32'h00);
    idle(3);
    rd(8'h1C, 32'd91, "R11 resumed from held count");

    // R10: coherent wide read on channel 1
    wr(8'h34, 32'h0);
    wr(8'h38, 32'h1);
    wr(8'h30, 32'h03);
    rd(8'h3C, 32'h0, "R10 count low at load value");
    rd(8'h40, 32'h1, "R10 captured high half");
    wr(8'h30, 32'h0);
    idle(5);

    // R9: enable masking, channel 1 one-shot interval 0
    wr(8'h38, 32'h0);
    wr(8'h30, 32'h83);
    idle(2);
    chk_irq(1'b0, "R9 masked channel pending");
    rd(8'h04, 32'h2, "R9 channel 1 status bit");
    wr(8'h00, 32'h3);
    chk_irq(1'b1, "R9 unmasked raises irq");
    wr(8'h04, 32'h2);
    chk_irq(1'b0, "R9 cleared drops irq");

    idle(2);
    summary();
    $finish;
  end
endmodule